// File: doc/BRIEF.md
# Debug Halt Control and Status Unit

This block is the register-mapped debug controller that sits beside a simple processor core. A debugger reaches it through a small 32-bit register bus. It holds three registers: a keyed halt control word that also reports core status, a set of fault flags that software clears by writing ones, and a monitor control word that enables vector catching and the watchpoint unit. From the core it takes single-cycle event strobes (breakpoint, watchpoint, external debug request, hard fault, instruction retired) and two level inputs (core reset active, halted acknowledge). It returns the halt request, single-step, interrupt-mask and watchpoint-enable controls.

A global debug enable bit gates everything. While it is clear, no event halts the core, no fault flag is set, and the halt and mask bits do not reach their outputs. The read port is combinational on the address. Asserting the read enable on the control word clears its two sticky status bits at the next clock edge.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A write to word 0 updates the control bits [0] enable, [1] halt, [2] step and [3] mask-interrupts only when wdata[31:16] is 0xA05F. Any other write to word 0 changes no bit.
- R2: Word 0 reads register-ready input at bit 16, halted-acknowledge input at bit 17, the retired sticky bit at 24 and the reset sticky bit at 25. All unused bits read as zero, and the unmapped word 3 reads as zero.
- R3: The retired and reset sticky bits are set by their core inputs. A read-enabled access to word 0 clears them at the next edge, unless the condition is present in that same cycle, in which case the bit stays 1.
- R4: While debug is enabled, a breakpoint, watchpoint, external request or vector catch sets the halt bit. A core reset without a vector catch clears it. An event beats a write in the same cycle.
- R5: halt_req_o and irq_mask_o are 0 whenever the enable bit is 0. step_en_o is the step bit ANDed with enable.
- R6: Word 1 holds the fault flags: [0] halt-by-write or step, [1] breakpoint, [2] watchpoint, [3] vector catch, [4] external request. Writing 1 to a bit clears it. Flags are set only while debug is enabled.
- R7: If a fault event and a write-one-to-clear of the same flag fall in the same cycle, the flag stays set.
- R8: Word 2 stores the reset vector catch at bit 0, the hard-fault vector catch at bit 10 and the watchpoint enable at bit 24. Every other bit reads zero. wpt_en_o follows bit 24.
- R9: With debug enabled, a core reset with reset catch set, or a hard fault with hard-fault catch set, sets the halt bit and fault flag 3.
- R10: With step and enable set, each retired strobe raises halt_req_o for exactly the following cycle and sets fault flag 0. A keyed write that sets both enable and halt also sets fault flag 0.
- R11: After rst_ni is asserted, all registers, sticky bits and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address of the register |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe, clears the sticky bits on word 0 |
| rdata_o | output | 32 | Combinational read data |
| ext_dbg_req_i | input | 1 | External debug request strobe |
| bkpt_hit_i | input | 1 | Breakpoint hit strobe |
| wpt_hit_i | input | 1 | Watchpoint hit strobe |
| core_reset_i | input | 1 | Core reset active |
| hard_fault_i | input | 1 | Hard fault taken strobe |
| retired_i | input | 1 | Instruction retired strobe |
| halted_ack_i | input | 1 | Core reports halted |
| reg_ready_i | input | 1 | Core register transfer ready |
| halt_req_o | output | 1 | Halt request to core |
| step_en_o | output | 1 | Single-step enable |
| irq_mask_o | output | 1 | Mask external interrupts |
| wpt_en_o | output | 1 | Watchpoint unit enable |

## Verification
Every register effect, including the halt, step and mask outputs, shows up one clock edge after the stimulus that causes it. The step pulse is high in the cycle after the retired strobe and is gone after the next edge. Read data and the halted and register-ready bits are combinational, so they follow the address and inputs within the same cycle. The bench drives stimulus on a falling edge, lets one rising edge pass, then idles the inputs and sets the check address on the next falling edge. It samples shortly after that, before any further rising edge, so sticky clears and pulses are seen in exactly their due cycle.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int          DATA_W    = 32;
  localparam logic [15:0] CTRL_KEY  = 16'hA05F;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_FAULT = 1;
  localparam int ADDR_MON   = 2;

  localparam int N_FAULT   = 5;
  localparam int FLT_HALT  = 0;
  localparam int FLT_BKPT  = 1;
  localparam int FLT_WPT   = 2;
  localparam int FLT_VC    = 3;
  localparam int FLT_EXT   = 4;

  localparam int MON_VC_RST = 0;
  localparam int MON_VC_HF  = 10;
  localparam int MON_WPT_EN = 24;

  localparam int ST_REGRDY  = 16;
  localparam int ST_HALTED  = 17;
  localparam int ST_RETIRED = 24;
  localparam int ST_RESET   = 25;

  localparam int N_STICKY   = 2;
  localparam int STK_RET    = 0;
  localparam int STK_RST    = 1;

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_halt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] key_i,
  input  logic [3:0]  bits_i,
  input  logic        evt_i,
  input  logic        core_reset_i,
  input  logic        retired_i,
  output ctrl_t       ctrl_o,
  output logic        step_fire_o,
  output logic        step_pulse_o,
  output logic        halt_wr_o
);
  ctrl_t ctrl_q;
  logic  step_pulse_q;
  logic  key_ok;

  assign key_ok      = wr_i && (key_i == CTRL_KEY);
  assign step_fire_o = ctrl_q.en & ctrl_q.step & retired_i;
  assign halt_wr_o   = key_ok & bits_i[0] & bits_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q       <= '0;
      step_pulse_q <= 1'b0;
    end else begin
      if (key_ok) begin
        ctrl_q.en   <= bits_i[0];
        ctrl_q.step <= bits_i[2];
        ctrl_q.mask <= bits_i[3];
      end
      // debug event beats core reset, which beats a write
      if (evt_i)             ctrl_q.halt <= 1'b1;
      else if (core_reset_i) ctrl_q.halt <= 1'b0;
      else if (key_ok)       ctrl_q.halt <= bits_i[1];
      step_pulse_q <= step_fire_o;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign step_pulse_o = step_pulse_q;

  assert_bad_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && key_i != CTRL_KEY && !evt_i && !core_reset_i) |=> $stable(ctrl_q));
  assert_evt_halt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> ctrl_q.halt);
  assert_rst_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_reset_i && !evt_i) |=> !ctrl_q.halt);
endmodule

// File: rtl/dbg_fault_flags.sv
module dbg_fault_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[k] <= 1'b0;
      else if (set_i[k]) flag_q[k] <= 1'b1;
      else if (clr_i[k]) flag_q[k] <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[k] && clr_i[k]) |=> flag_q[k]);
    assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !flag_q[k]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dbg_sticky.sv
module dbg_sticky #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cond_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] bit_o
);
  logic [N-1:0] bit_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        bit_q[k] <= 1'b0;
      else if (cond_i[k]) bit_q[k] <= 1'b1;
      else if (rd_clr_i)  bit_q[k] <= 1'b0;
    end

    assert_sticky_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_i[k] |=> bit_q[k]);
    assert_sticky_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_clr_i && !cond_i[k]) |=> !bit_q[k]);
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  input  logic              ext_dbg_req_i,
  input  logic              bkpt_hit_i,
  input  logic              wpt_hit_i,
  input  logic              core_reset_i,
  input  logic              hard_fault_i,
  input  logic              retired_i,
  input  logic              halted_ack_i,
  input  logic              reg_ready_i,
  output logic              halt_req_o,
  output logic              step_en_o,
  output logic              irq_mask_o,
  output logic              wpt_en_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_FAULT = ADDR_W'(ADDR_FAULT);
  localparam logic [ADDR_W-1:0] A_MON   = ADDR_W'(ADDR_MON);

  ctrl_t              ctrl;
  logic               dbg_en, step_fire, step_pulse, halt_wr;
  logic               vc_rst_q, vc_hf_q, wpt_en_q;
  logic               vc_hit, evt;
  logic               wr_ctrl, wr_fault, wr_mon, rd_ctrl;
  logic [N_FAULT-1:0] flt_set, flt_clr, flt;
  logic [N_STICKY-1:0] stk_cond, stk;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata_i[15:11], wdata_i[9:5]};

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_fault = wr_en_i && (addr_i == A_FAULT);
  assign wr_mon   = wr_en_i && (addr_i == A_MON);
  assign rd_ctrl  = rd_en_i && (addr_i == A_CTRL);

  assign dbg_en = ctrl.en;
  assign vc_hit = dbg_en & ((core_reset_i & vc_rst_q) | (hard_fault_i & vc_hf_q));
  assign evt    = (dbg_en & (bkpt_hit_i | wpt_hit_i | ext_dbg_req_i)) | vc_hit;

  dbg_ctrl_reg u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_ctrl),
    .key_i        (wdata_i[31:16]),
    .bits_i       (wdata_i[3:0]),
    .evt_i        (evt),
    .core_reset_i (core_reset_i),
    .retired_i    (retired_i),
    .ctrl_o       (ctrl),
    .step_fire_o  (step_fire),
    .step_pulse_o (step_pulse),
    .halt_wr_o    (halt_wr)
  );

  always_comb begin
    flt_set           = '0;
    flt_set[FLT_HALT] = dbg_en & (step_fire | halt_wr);
    flt_set[FLT_BKPT] = dbg_en & bkpt_hit_i;
    flt_set[FLT_WPT]  = dbg_en & wpt_hit_i;
    flt_set[FLT_VC]   = vc_hit;
    flt_set[FLT_EXT]  = dbg_en & ext_dbg_req_i;
  end
  assign flt_clr = wr_fault ? wdata_i[N_FAULT-1:0] : '0;

  dbg_fault_flags #(.N(N_FAULT)) u_fault (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flt_set),
    .clr_i  (flt_clr),
    .flag_o (flt)
  );

  always_comb begin
    stk_cond          = '0;
    stk_cond[STK_RET] = retired_i;
    stk_cond[STK_RST] = core_reset_i;
  end

  dbg_sticky #(.N(N_STICKY)) u_sticky (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cond_i   (stk_cond),
    .rd_clr_i (rd_ctrl),
    .bit_o    (stk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vc_rst_q <= 1'b0;
      vc_hf_q  <= 1'b0;
      wpt_en_q <= 1'b0;
    end else if (wr_mon) begin
      vc_rst_q <= wdata_i[MON_VC_RST];
      vc_hf_q  <= wdata_i[MON_VC_HF];
      wpt_en_q <= wdata_i[MON_WPT_EN];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[3:0]       = ctrl;
        rdata_o[ST_REGRDY]  = reg_ready_i;
        rdata_o[ST_HALTED]  = halted_ack_i;
        rdata_o[ST_RETIRED] = stk[STK_RET];
        rdata_o[ST_RESET]   = stk[STK_RST];
      end
      A_FAULT: rdata_o[N_FAULT-1:0] = flt;
      A_MON: begin
        rdata_o[MON_VC_RST] = vc_rst_q;
        rdata_o[MON_VC_HF]  = vc_hf_q;
        rdata_o[MON_WPT_EN] = wpt_en_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign halt_req_o = dbg_en & (ctrl.halt | step_pulse);
  assign step_en_o  = dbg_en & ctrl.step;
  assign irq_mask_o = dbg_en & ctrl.mask;
  assign wpt_en_o   = wpt_en_q;

  assert_step_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.en && ctrl.step && retired_i && !wr_ctrl) |=> halt_req_o);
  assert_vc_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_en && vc_rst_q && core_reset_i && !wr_ctrl) |=> (halt_req_o && flt[FLT_VC]));
  assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_en |-> (!halt_req_o && !irq_mask_o && !step_en_o));
endmodule

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;
  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [6:0]  ev;   // [6]rd [5]ret [4]hf [3]crst [2]wpt [1]bkpt [0]ext
    logic [1:0]  chk;
    logic [31:0] exp;
    logic [3:0]  out;  // [3]wpt_en [2]irq_mask [1]step_en [0]halt_req
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 32'h0,         7'h00, 2'd0, 32'h0,         4'b0000},
    '{1'b1, 2'd0, 32'h1234_0003, 7'h00, 2'd0, 32'h0,         4'b0000},
    '{1'b0, 2'd0, 32'h0,         7'h02, 2'd1, 32'h0,         4'b0000},
    '{1'b1, 2'd0, 32'hA05F_0001, 7'h00, 2'd0, 32'h1,         4'b0000},
    '{1'b0, 2'd0, 32'h0,         7'h02, 2'd1, 32'h2,         4'b0001},
    '{1'b1, 2'd1, 32'h2,         7'h00, 2'd1, 32'h0,         4'b0001},
    '{1'b1, 2'd0, 32'hA05F_0001, 7'h00, 2'd0, 32'h1,         4'b0000},
    '{1'b1, 2'd0, 32'hA05F_0009, 7'h00, 2'd0, 32'h9,         4'b0100},
    '{1'b1, 2'd0, 32'hA05F_0008, 7'h00, 2'd0, 32'h8,         4'b0000},
    '{1'b1, 2'd0, 32'hA05F_0005, 7'h00, 2'd0, 32'h5,         4'b0010},
    '{1'b0, 2'd0, 32'h0,         7'h20, 2'd1, 32'h1,         4'b0011},
    '{1'b0, 2'd0, 32'h0,         7'h00, 2'd0, 32'h0100_0005, 4'b0010},
    '{1'b0, 2'd0, 32'h0,         7'h40, 2'd0, 32'h5,         4'b0010},
    '{1'b1, 2'd1, 32'h4,         7'h04, 2'd1, 32'h5,         4'b0011},
    '{1'b1, 2'd2, 32'h0100_0401, 7'h00, 2'd2, 32'h0100_0401, 4'b1011},
    '{1'b1, 2'd0, 32'hA05F_0001, 7'h00, 2'd0, 32'h1,         4'b1000},
    '{1'b1, 2'd1, 32'h1F,        7'h00, 2'd1, 32'h0,         4'b1000},
    '{1'b0, 2'd0, 32'h0,         7'h08, 2'd1, 32'h8,         4'b1001},
    '{1'b0, 2'd0, 32'h0,         7'h00, 2'd0, 32'h0200_0003, 4'b1001},
    '{1'b0, 2'd0, 32'h0,         7'h48, 2'd0, 32'h0200_0003, 4'b1001},
    '{1'b0, 2'd0, 32'h0,         7'h40, 2'd0, 32'h3,         4'b1001},
    '{1'b1, 2'd2, 32'h0100_0400, 7'h00, 2'd2, 32'h0100_0400, 4'b1001},
    '{1'b0, 2'd0, 32'h0,         7'h08, 2'd0, 32'h0200_0001, 4'b1000},
    '{1'b1, 2'd1, 32'h8,         7'h00, 2'd1, 32'h0,         4'b1000},
    '{1'b0, 2'd0, 32'h0,         7'h10, 2'd1, 32'h8,         4'b1001},
    '{1'b0, 2'd0, 32'h0,         7'h01, 2'd1, 32'h18,        4'b1001},
    '{1'b1, 2'd2, 32'hFFFF_FFFF, 7'h00, 2'd2, 32'h0100_0401, 4'b1001},
    '{1'b1, 2'd0, 32'hA05F_FFFF, 7'h00, 2'd0, 32'h0200_000F, 4'b1111},
    '{1'b1, 2'd0, 32'hA05F_0000, 7'h00, 2'd0, 32'h0200_0000, 4'b1000},
    '{1'b0, 2'd0, 32'h0,         7'h02, 2'd1, 32'h19,        4'b1000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext_req = 1'b0, bkpt = 1'b0, wpt = 1'b0, crst = 1'b0;
  logic        hfault = 1'b0, retired = 1'b0, hack = 1'b0, rrdy = 1'b0;
  logic        halt_req, step_en, irq_mask, wpt_en;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dbg_halt_ctrl #(.ADDR_W(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .ext_dbg_req_i(ext_req), .bkpt_hit_i(bkpt), .wpt_hit_i(wpt),
    .core_reset_i(crst), .hard_fault_i(hfault), .retired_i(retired),
    .halted_ack_i(hack), .reg_ready_i(rrdy),
    .halt_req_o(halt_req), .step_en_o(step_en),
    .irq_mask_o(irq_mask), .wpt_en_o(wpt_en)
  );

  function automatic string vec_tag(int i);
    case (i)
      0:              return "R11";
      1, 3, 6, 15:    return "R1";
      4, 22:          return "R4";
      7, 8, 9, 28:    return "R5";
      10, 27:         return "R10";
      11, 12, 18, 19, 20: return "R3";
      13:             return "R7";
      14, 21, 26:     return "R8";
      17, 24:         return "R9";
      default:        return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    {ext_req, bkpt, wpt, crst, hfault, retired} = '0;
  endtask

  task automatic run_vec(int i);
    vec_t v = VECS[i];
    @(negedge clk);
    wr_en = v.wr; addr = v.addr; wdata = v.wdata;
    {rd_en, retired, hfault, crst, wpt, bkpt, ext_req} = v.ev;
    @(negedge clk);
    idle();
    addr = v.chk;
    #1;
    check(vec_tag(i), rdata, v.exp);
    check(vec_tag(i), {28'h0, wpt_en, irq_mask, step_en, halt_req}, {28'h0, v.out});
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: status mirrors and unmapped word
    @(negedge clk);
    hack = 1'b1; rrdy = 1'b1; addr = 2'd0; #1;
    check("R2", rdata, 32'h0203_0000);
    addr = 2'd3; #1;
    check("R2", rdata, 32'h0);

    // R5: halt bit set while disabled does not request halt; R6: no fault set
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 32'hA05F_0002;
    @(negedge clk);
    idle(); addr = 2'd1; #1;
    check("R5", {31'h0, halt_req}, 32'h0);
    check("R6", rdata, 32'h19);

    // R11: asynchronous reset clears everything
    @(negedge clk);
    hack = 1'b0; rrdy = 1'b0; rst_n = 1'b0; #1;
    check("R11", {28'h0, wpt_en, irq_mask, step_en, halt_req}, 32'h0);
    addr = 2'd0; #1; check("R11", rdata, 32'h0);
    addr = 2'd1; #1; check("R11", rdata, 32'h0);
    addr = 2'd2; #1; check("R11", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule